// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic-Logic Unit with Condition Flags

This block is a purely combinational arithmetic-logic unit. It takes two operands and a three-bit operation code. It returns a result word and a four-bit condition vector in the same evaluation, so a datapath can latch both on its next clock edge. Two of the eight codes are arithmetic: addition, and subtraction done as the first operand plus the inverted second operand plus one. The other six codes are bitwise logic operations: AND, OR and XOR, and their inverted forms.

The condition vector holds four flags. Zero is set for an all-zero result. Negative is the sign bit of the result. Carry is the carry out of the adder. Overflow is the signed overflow of the adder. Zero and negative follow the result for every code. Carry and overflow have meaning only for the two arithmetic codes and are held low for the logic codes.

The operand width is a parameter with a default of 16. The opcode map and the flag packing do not depend on it. There is no state, no clock and no reset: each output depends only on the present inputs.

Top module: `alu16_flags`

## Requirements
- R1: With op_sel = 3'b000 (add), result equals (opnd_a + opnd_b) modulo 2^WIDTH.
- R2: With op_sel = 3'b001 (subtract), result equals (opnd_a - opnd_b) modulo 2^WIDTH, formed as opnd_a + ~opnd_b + 1.
- R3: The logic codes give bitwise results: 3'b010 AND, 3'b011 XOR, 3'b100 NAND, 3'b101 XNOR, 3'b110 OR, 3'b111 NOR.
- R4: flags[3] (zero) is 1 exactly when every result bit is 0, for every op_sel value.
- R5: flags[2] (negative) equals result[WIDTH-1], for every op_sel value.
- R6: flags[1] (carry) is the carry out of bit WIDTH-1 of the adder. For add, the adder computes opnd_a + opnd_b. For subtract, it computes opnd_a + ~opnd_b + 1, so carry is 1 when opnd_a >= opnd_b unsigned.
- R7: flags[0] (overflow) is 1 when the two adder inputs have the same sign bit and the result sign bit differs from it. The adder inputs are opnd_a and opnd_b for add, and opnd_a and ~opnd_b for subtract.
- R8: For every logic code (op_sel[2:1] != 2'b00), flags[1] and flags[0] are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand (the subtrahend for subtract) |
| op_sel | input | 3 | Operation code |
| result | output | WIDTH | Operation result |
| flags | output | 4 | {zero, negative, carry, overflow}, zero in the most significant bit |

## Verification
The unit holds no state. A wrong internal value, such as a broken carry link, a misrouted logic term or a missed flag gate, shows at result or flags in the same evaluation as the operands that trigger it. The only condition is that the operands actually exercise the faulty path.

A four-bit copy of the unit is swept over every operand pair and every code, so every carry chain and sign combination occurs. The sixteen-bit unit is driven with the sign and carry boundary words and with random operands. In both cases every output bit is compared with an arithmetic model.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int FLAG_W = 4;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_AND  = 3'b010,
        OP_XOR  = 3'b011,
        OP_NAND = 3'b100,
        OP_XNOR = 3'b101,
        OP_OR   = 3'b110,
        OP_NOR  = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic carry;
        logic ovf;
    } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   chain;

    assign b_eff    = b ^ {WIDTH{sub}};
    assign chain[0] = sub;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        assign sum[i]       = a[i] ^ b_eff[i] ^ chain[i];
        assign chain[i + 1] = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
    end

    assign carry_out = chain[WIDTH];
    assign ovf       = ~(a[MSB] ^ b_eff[MSB]) & (sum[MSB] ^ a[MSB]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_pkg::alu_op_e op,
    output logic [WIDTH-1:0] y
);
    import alu_pkg::*;

    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_XOR:  y = a ^ b;
            OP_NAND: y = ~(a & b);
            OP_XNOR: y = ~(a ^ b);
            OP_OR:   y = a | b;
            OP_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_flagger.sv
module alu_flagger #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]  res,
    input  logic              carry_raw,
    input  logic              ovf_raw,
    input  logic              is_arith,
    output alu_pkg::alu_flags_t flg
);
    always_comb begin
        flg.zero  = ~|res;
        flg.neg   = res[WIDTH-1];
        flg.carry = is_arith & carry_raw;
        flg.ovf   = is_arith & ovf_raw;
    end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic [3:0]       flags
);
    import alu_pkg::*;

    alu_op_e          op;
    logic             is_arith;
    logic [WIDTH-1:0] arith_y;
    logic [WIDTH-1:0] logic_y;
    logic             carry_raw;
    logic             ovf_raw;
    alu_flags_t       flg;

    assign op       = alu_op_e'(op_sel);
    assign is_arith = (op_sel[2:1] == 2'b00);

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a         (opnd_a),
        .b         (opnd_b),
        .sub       (op_sel[0]),
        .sum       (arith_y),
        .carry_out (carry_raw),
        .ovf       (ovf_raw)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a  (opnd_a),
        .b  (opnd_b),
        .op (op),
        .y  (logic_y)
    );

    assign result = is_arith ? arith_y : logic_y;

    alu_flagger #(.WIDTH(WIDTH)) u_flags (
        .res       (result),
        .carry_raw (carry_raw),
        .ovf_raw   (ovf_raw),
        .is_arith  (is_arith),
        .flg       (flg)
    );

    assign flags = flg;
endmodule

// File: rtl/alu16_flags_chk.sv
module alu16_flags_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] result,
    input logic [3:0]       flags
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   wide_add;
    logic [WIDTH:0]   wide_sub;
    logic [WIDTH-1:0] nb;

    assign nb       = ~opnd_b;
    assign wide_add = {1'b0, opnd_a} + {1'b0, opnd_b};
    assign wide_sub = {1'b0, opnd_a} + {1'b0, nb} + {{WIDTH{1'b0}}, 1'b1};

    always_comb begin
        if (op_sel == 3'b000) begin
            p_add_r1: assert ({flags[1], result} == wide_add);
            p_add_ovf_r7: assert (flags[0] == ((opnd_a[MSB] == opnd_b[MSB]) && (wide_add[MSB] != opnd_a[MSB])));
        end
        if (op_sel == 3'b001) begin
            p_sub_r2: assert (result == opnd_a - opnd_b);
            p_sub_carry_r6: assert (flags[1] == (opnd_a >= opnd_b));
        end
        if (op_sel == 3'b100) begin
            p_nand_r3: assert (result == ~(opnd_a & opnd_b));
        end
        if (op_sel[2:1] != 2'b00) begin
            p_no_arith_flags_r8: assert (flags[1:0] == 2'b00);
        end
        p_zero_r4: assert (!flags[3] || (result == '0));
        p_neg_r5: assert (flags[2] == result[MSB]);
    end
endmodule

bind alu16_flags alu16_flags_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .op_sel (op_sel),
    .result (result),
    .flags  (flags)
);

// File: tb/tb_alu16_flags.sv
module tb_alu16_flags;
    localparam int W  = 16;
    localparam int WS = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [W-1:0]  a = '0, b = '0, res;
    logic [2:0]    op = 3'b000;
    logic [3:0]    flg;
    logic [WS-1:0] as = '0, bs = '0, ress;
    logic [2:0]    ops = 3'b000;
    logic [3:0]    flgs;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    alu16_flags #(.WIDTH(W)) dut (
        .opnd_a(a), .opnd_b(b), .op_sel(op), .result(res), .flags(flg));
    alu16_flags #(.WIDTH(WS)) dut_small (
        .opnd_a(as), .opnd_b(bs), .op_sel(ops), .result(ress), .flags(flgs));

    // Arithmetic model: returns {result[w-1:0], Z, N, C, V} in a 36-bit word.
    function automatic logic [35:0] model(input int w, input logic [2:0] o,
                                          input logic [31:0] x, input logic [31:0] y);
        logic [31:0] mask, sum, r, yb;
        logic c, v, z, n;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
        c = 1'b0; v = 1'b0;
        yb = (o == 3'b001) ? (~y & mask) : y;
        case (o)
            3'b000, 3'b001: begin
                sum = x + yb + ((o == 3'b001) ? 32'd1 : 32'd0);
                r = sum & mask;
                c = sum[w];
                v = (x[w-1] == yb[w-1]) && (r[w-1] != x[w-1]);
            end
            3'b010: r = x & y;
            3'b011: r = x ^ y;
            3'b100: r = ~(x & y) & mask;
            3'b101: r = ~(x ^ y) & mask;
            3'b110: r = x | y;
            default: r = ~(x | y) & mask;
        endcase
        z = (r == 0);
        n = r[w-1];
        return {r, z, n, c, v};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, o, x, y, act, exp);
        end
    endtask

    function automatic string res_tag(input logic [2:0] o);
        if (o == 3'b000) return "R1";
        if (o == 3'b001) return "R2";
        return "R3";
    endfunction

    task automatic compare(input int w, input logic [2:0] o, input logic [31:0] x,
                           input logic [31:0] y, input logic [31:0] r, input logic [3:0] f);
        logic [35:0] m;
        bit lg;
        m  = model(w, o, x, y);
        lg = (o[2:1] != 2'b00);
        chk(res_tag(o), r, m[35:4], o, x, y);
        chk("R4", {31'd0, f[3]}, {31'd0, m[3]}, o, x, y);
        chk("R5", {31'd0, f[2]}, {31'd0, m[2]}, o, x, y);
        chk(lg ? "R8" : "R6", {31'd0, f[1]}, {31'd0, m[1]}, o, x, y);
        chk(lg ? "R8" : "R7", {31'd0, f[0]}, {31'd0, m[0]}, o, x, y);
    endtask

    task automatic run16(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        @(posedge clk);
        op = o; a = x; b = y;
        @(negedge clk);
        compare(W, o, {16'd0, x}, {16'd0, y}, {16'd0, res}, flg);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    logic [W-1:0] corners [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                  16'hFFFF, 16'h5555, 16'hAAAA, 16'h1234};

    initial begin
        // Quiescent state: all-zero inputs with add give zero result and only Z set (R4, R1).
        @(negedge clk);
        chk("R1", {16'd0, res}, 32'd0, op, 0, 0);
        chk("R4", {28'd0, flg}, 32'h8, op, 0, 0);

        // Exhaustive sweep of the 4-bit copy: all codes, all operand pairs.
        for (int o = 0; o < 8; o++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++) begin
                    @(posedge clk);
                    ops = o[2:0]; as = x[WS-1:0]; bs = y[WS-1:0];
                    @(negedge clk);
                    compare(WS, o[2:0], x, y, {28'd0, ress}, flgs);
                end

        // Boundary words on the 16-bit unit.
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run16(o[2:0], corners[i], corners[j]);

        // Directed: R6 carry on 0xFFFF+1, R7 overflow on 0x7FFF+1, R2 borrow case.
        run16(3'b000, 16'hFFFF, 16'h0001);
        chk("R6", {31'd0, flg[1]}, 32'd1, 3'b000, 16'hFFFF, 1);
        run16(3'b000, 16'h7FFF, 16'h0001);
        chk("R7", {31'd0, flg[0]}, 32'd1, 3'b000, 16'h7FFF, 1);
        run16(3'b001, 16'h0000, 16'h0001);
        chk("R6", {31'd0, flg[1]}, 32'd0, 3'b001, 0, 1);
        run16(3'b001, 16'h8000, 16'h0001);
        chk("R7", {31'd0, flg[0]}, 32'd1, 3'b001, 16'h8000, 1);
        run16(3'b111, 16'h0000, 16'h0000);
        chk("R8", {30'd0, flg[1:0]}, 32'd0, 3'b111, 0, 0);

        // Random operands on the 16-bit unit.
        for (int k = 0; k < 2000; k++)
            run16(3'($urandom_range(7)), 16'($urandom), 16'($urandom));

        finish_run();
    end
endmodule